// File: doc/BRIEF.md
# Indexed codec control register file

This block is the host-facing control interface of a simple audio codec. A byte-wide bus with a two-bit address reaches four direct ports: 0 is the index pointer, 1 is the data window onto the indirect register selected by the pointer, 2 is a read-only status byte, and 3 is a programmed-I/O data port that is not implemented. The data window leads into a bank of 32 eight-bit indirect registers.

Each indirect register has its own write rule. Some registers are fixed, some are partly writable, and some are masked. A mode bit chooses whether the index uses 16 or 32 registers. The playback-format register can be written only under mode-change control. A calibration-busy indication shows for a preset number of reads after the host enters mode-change state.

The format, configuration, pin, playback base count and feature-status registers are sent to a playback engine as parallel outputs. A one-cycle strobe marks each committed write to the format or configuration register. The engine returns its interrupt flag, which the status port shows.

Top module: `idx_codec_regs`

## Requirements
- R1: After reset, the pointer reads 0x40, so mode-change enable (pointer bit 6) is set. Indirect registers 2, 3, 4, 5, 18 and 19 read 0x88. Registers 6 and 7 read 0x80. Register 9 reads 0x08, register 12 reads 0x8A, and registers 25 and 26 read 0xA0. Every other register reads 0x00.
- R2: A write to port 0 stores bits 6:0 of the written byte. A read of port 0 returns the stored value with bit 7 at 0.
- R3: When bit 6 of register 12 is 0, pointer bits 3:0 select the indirect register. When it is 1, pointer bits 4:0 select it.
- R4: A write to register 12 changes only bit 6. The other bits keep their reset pattern, 0x8A with bit 6 masked.
- R5: Writes to registers 11, 22, 27 and 29 leave their contents unchanged.
- R6: A write to register 8 with pointer bit 6 set stores the full byte. With pointer bit 6 clear and bit 4 of register 24 set, the write stores only bits 7:4 and keeps bits 3:0. With both bits clear, the write is discarded.
- R7: A write to register 9 always stores bit 5 as 0.
- R8: A port-0 write that takes pointer bit 6 from 0 to 1, while bits 4:3 of register 9 are nonzero, loads a counter with CAL_PRESET. Each read of register 11 while the counter is nonzero returns bit 5 set and decrements the counter. No load happens if bits 4:3 of register 9 are zero.
- R9: A read of port 2 returns {7'b0, pb_irq}. A read of port 3 returns 0x00, and writes to port 3 have no effect.
- R10: pb_fmt, pb_cfg, pb_pin, pb_cnt_hi, pb_cnt_lo and pb_alt always equal registers 8, 9, 10, 14, 15 and 24. pb_upd is high for exactly the cycle after a write commits to register 8 or 9, and stays low after a discarded or unrelated write.
- R11: bus_rdata is registered. It takes the read result on the clock edge that samples bus_rd and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Direct port select |
| bus_wr | input | 1 | Write strobe, one byte |
| bus_rd | input | 1 | Read strobe, one byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pb_irq | input | 1 | Interrupt flag from the playback engine |
| pb_fmt | output | 8 | Playback format register |
| pb_cfg | output | 8 | Interface configuration register |
| pb_pin | output | 8 | Pin control register |
| pb_cnt_hi | output | 8 | Playback base count, upper byte |
| pb_cnt_lo | output | 8 | Playback base count, lower byte |
| pb_alt | output | 8 | Feature status register |
| pb_upd | output | 1 | One-cycle strobe after a committed format or config write |

## Verification
The hardest case to reach is the partial format write. It needs mode-change enable cleared and, at the same time, bit 4 of register 24 set. Register 24 is visible only in the 32-register mode, so the stimulus drops the pointer's bit 6, enables the wide mode through register 12, sets register 24, and only then writes register 8. The calibration flag is reached in a similar way. The bench first writes the configuration bits that arm it, then makes a deliberate 0-to-1 pointer transition. The same transition is then repeated with the arming bits cleared, to show that no load occurs.

// File: rtl/codec_reg_pkg.sv
package codec_reg_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  localparam int REG_FMT    = 8;
  localparam int REG_CFG    = 9;
  localparam int REG_PIN    = 10;
  localparam int REG_INIT   = 11;
  localparam int REG_MODE   = 12;
  localparam int REG_CNT_HI = 14;
  localparam int REG_CNT_LO = 15;
  localparam int REG_RSV_A  = 22;
  localparam int REG_ALT    = 24;
  localparam int REG_RSV_B  = 27;
  localparam int REG_RSV_C  = 29;

  localparam int MCE_BIT     = 6;
  localparam int WIDE_BIT    = 6;
  localparam int CAL_BIT     = 5;
  localparam int CFG_RSV_BIT = 5;
  localparam int PMC_BIT     = 4;

  function automatic byte_t reset_value(input int idx);
    case (idx)
      2, 3, 4, 5, 18, 19: reset_value = 8'h88;
      6, 7:               reset_value = 8'h80;
      REG_CFG:            reset_value = 8'h08;
      REG_MODE:           reset_value = 8'h8A;
      25, 26:             reset_value = 8'hA0;
      default:            reset_value = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/codec_index_dec.sv
module codec_index_dec #(
  parameter int AW = 5
) (
  input  logic [AW-1:0] idx_bits,
  input  logic          wide_mode,
  output logic [AW-1:0] sel
);
  localparam int NW = AW - 1;

  always_comb begin
    if (wide_mode) sel = idx_bits;
    else           sel = {1'b0, idx_bits[NW-1:0]};
  end
endmodule

// File: rtl/codec_cal_flag.sv
module codec_cal_flag #(
  parameter int CAL_W      = 4,
  parameter int CAL_PRESET = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic rd_hit,
  output logic active
);
  logic [CAL_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                         cnt <= '0;
    else if (load)                   cnt <= CAL_W'(CAL_PRESET);
    else if (rd_hit && cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign active = (cnt != '0);
endmodule

// File: rtl/codec_reg_bank.sv
module codec_reg_bank
  import codec_reg_pkg::*;
#(
  parameter int NREG = 32,
  parameter int AW   = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] sel,
  input  byte_t         wdata,
  input  logic          mce,
  output byte_t         rd_val,
  output byte_t         mode_byte,
  output byte_t         fmt,
  output byte_t         cfg,
  output byte_t         pin,
  output byte_t         cnt_hi,
  output byte_t         cnt_lo,
  output byte_t         alt,
  output logic          upd
);
  byte_t bank [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) bank[i] <= reset_value(i);
      upd <= 1'b0;
    end else begin
      upd <= 1'b0;
      if (wr_en) begin
        case (sel)
          AW'(REG_RSV_A), AW'(REG_RSV_B), AW'(REG_RSV_C), AW'(REG_INIT): ;
          AW'(REG_FMT): begin
            if (mce) begin
              bank[sel] <= wdata;
              upd       <= 1'b1;
            end else if (bank[REG_ALT][PMC_BIT]) begin
              bank[sel] <= {wdata[7:4], bank[REG_FMT][3:0]};
              upd       <= 1'b1;
            end
          end
          AW'(REG_CFG): begin
            bank[sel] <= wdata & ~(byte_t'(1) << CFG_RSV_BIT);
            upd       <= 1'b1;
          end
          AW'(REG_MODE): begin
            bank[sel] <= (bank[REG_MODE] & ~(byte_t'(1) << WIDE_BIT))
                       | (wdata & (byte_t'(1) << WIDE_BIT));
          end
          default: bank[sel] <= wdata;
        endcase
      end
    end
  end

  assign rd_val    = bank[sel];
  assign mode_byte = bank[REG_MODE];
  assign fmt       = bank[REG_FMT];
  assign cfg       = bank[REG_CFG];
  assign pin       = bank[REG_PIN];
  assign cnt_hi    = bank[REG_CNT_HI];
  assign cnt_lo    = bank[REG_CNT_LO];
  assign alt       = bank[REG_ALT];
endmodule

// File: rtl/idx_codec_regs.sv
module idx_codec_regs
  import codec_reg_pkg::*;
#(
  parameter int NREG       = 32,
  parameter int CAL_W      = 4,
  parameter int CAL_PRESET = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       pb_irq,
  output logic [7:0] pb_fmt,
  output logic [7:0] pb_cfg,
  output logic [7:0] pb_pin,
  output logic [7:0] pb_cnt_hi,
  output logic [7:0] pb_cnt_lo,
  output logic [7:0] pb_alt,
  output logic       pb_upd
);
  localparam int AW = $clog2(NREG);
  localparam logic [1:0] P_INDEX  = 2'd0;
  localparam logic [1:0] P_DATA   = 2'd1;
  localparam logic [1:0] P_STATUS = 2'd2;

  byte_t         idx_reg;
  byte_t         rd_val;
  byte_t         mode_byte;
  logic [AW-1:0] sel;
  logic          cal_active;
  logic          cal_load;
  logic          cal_rd_hit;
  logic          data_wr;

  assign data_wr = bus_wr && bus_addr == P_DATA;

  always_ff @(posedge clk) begin
    if (rst)                               idx_reg <= 8'h40;
    else if (bus_wr && bus_addr == P_INDEX) idx_reg <= bus_wdata & 8'h7F;
  end

  codec_index_dec #(.AW(AW)) dec_i (
    .idx_bits (idx_reg[AW-1:0]),
    .wide_mode(mode_byte[WIDE_BIT]),
    .sel      (sel)
  );

  codec_reg_bank #(.NREG(NREG), .AW(AW)) bank_i (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (data_wr),
    .sel      (sel),
    .wdata    (bus_wdata),
    .mce      (idx_reg[MCE_BIT]),
    .rd_val   (rd_val),
    .mode_byte(mode_byte),
    .fmt      (pb_fmt),
    .cfg      (pb_cfg),
    .pin      (pb_pin),
    .cnt_hi   (pb_cnt_hi),
    .cnt_lo   (pb_cnt_lo),
    .alt      (pb_alt),
    .upd      (pb_upd)
  );

  assign cal_load   = bus_wr && bus_addr == P_INDEX && !idx_reg[MCE_BIT]
                   && bus_wdata[MCE_BIT] && (pb_cfg[4:3] != 2'b00);
  assign cal_rd_hit = bus_rd && bus_addr == P_DATA && sel == AW'(REG_INIT);

  codec_cal_flag #(.CAL_W(CAL_W), .CAL_PRESET(CAL_PRESET)) cal_i (
    .clk   (clk),
    .rst   (rst),
    .load  (cal_load),
    .rd_hit(cal_rd_hit),
    .active(cal_active)
  );

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= 8'h00;
    else if (bus_rd) begin
      case (bus_addr)
        P_INDEX:  bus_rdata <= idx_reg;
        P_DATA:   bus_rdata <= rd_val | ((cal_rd_hit && cal_active) ? 8'h20 : 8'h00);
        P_STATUS: bus_rdata <= {7'b0, pb_irq};
        default:  bus_rdata <= 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/codec_regs_chk.sv
module codec_regs_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] bus_addr,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic [7:0] bus_rdata,
  input logic       pb_irq,
  input logic [7:0] pb_fmt,
  input logic [7:0] pb_cfg,
  input logic       pb_upd,
  input logic [7:0] mode_byte,
  input logic [4:0] sel,
  input logic       cal_active
);
  AST_IDX_MSB_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == 2'd0) |=> !bus_rdata[7]); // R2
  AST_INDEX_NARROW: assert property (@(posedge clk) disable iff (rst)
    !mode_byte[6] |-> !sel[4]); // R3
  AST_MODE_FIXED_BITS: assert property (@(posedge clk) disable iff (rst)
    (mode_byte & 8'hBF) == 8'h8A); // R4
  AST_FMT_ONLY_WITH_STB: assert property (@(posedge clk) disable iff (rst)
    !pb_upd |-> $stable(pb_fmt)); // R6
  AST_CFG_RSV_ZERO: assert property (@(posedge clk) disable iff (rst)
    !pb_cfg[5]); // R7
  AST_CAL_FLAG_SHOWN: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == 2'd1 && sel == 5'd11 && cal_active) |=> bus_rdata[5]); // R8
  AST_STATUS_LIVE: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == 2'd2) |=> bus_rdata == {7'b0, $past(pb_irq)}); // R9
  AST_STB_SOURCE: assert property (@(posedge clk) disable iff (rst)
    pb_upd |-> $past(bus_wr && bus_addr == 2'd1)); // R10
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata)); // R11
endmodule

bind idx_codec_regs codec_regs_chk chk_i (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .pb_irq    (pb_irq),
  .pb_fmt    (pb_fmt),
  .pb_cfg    (pb_cfg),
  .pb_upd    (pb_upd),
  .mode_byte (mode_byte),
  .sel       (sel),
  .cal_active(cal_active)
);

// File: tb/idx_codec_regs_tb_top.sv
`timescale 1ns/1ps
module idx_codec_regs_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       pb_irq = 1'b0;
  logic [7:0] pb_fmt, pb_cfg, pb_pin, pb_cnt_hi, pb_cnt_lo, pb_alt;
  logic       pb_upd;

  int n_vec = 0;
  int n_bad = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_q = 1'b0;
  logic       done = 1'b0;

  always #4 clk = ~clk;

  idx_codec_regs dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pb_irq(pb_irq),
    .pb_fmt(pb_fmt), .pb_cfg(pb_cfg), .pb_pin(pb_pin), .pb_cnt_hi(pb_cnt_hi),
    .pb_cnt_lo(pb_cnt_lo), .pb_alt(pb_alt), .pb_upd(pb_upd)
  );

  always @(posedge clk) rd_q <= bus_rd;

  // monitor: compare each read result against the scoreboard head
  always @(negedge clk) begin
    if (rd_q) begin
      logic [7:0] e;
      string      t;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL scoreboard: unexpected read result %02h, expected none", bus_rdata);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_vec++;
        if (bus_rdata !== e) begin
          n_bad++;
          $display("FAIL %s: read %02h expected %02h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(posedge clk);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic ireg_write(input logic [7:0] idx, input logic [7:0] d);
    bus_write(2'd0, idx);
    bus_write(2'd1, d);
  endtask

  task automatic ireg_read(input logic [7:0] idx, input logic [7:0] e, input string t);
    bus_write(2'd0, idx);
    bus_read(2'd1, e, t);
  endtask

  task automatic check(input logic [7:0] act, input logic [7:0] e, input string t);
    n_vec++;
    if (act !== e) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", t, act, e);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset values, 16-register view with pointer bit 6 kept set
    bus_read(2'd0, 8'h40, "R1 pointer reset");
    for (int i = 0; i < 16; i++) begin
      logic [7:0] e;
      case (i)
        2, 3, 4, 5: e = 8'h88;
        6, 7:       e = 8'h80;
        9:          e = 8'h08;
        12:         e = 8'h8A;
        default:    e = 8'h00;
      endcase
      ireg_read(8'h40 | 8'(i), e, "R1 indirect reset");
    end
    check({7'b0, pb_upd}, 8'h00, "R10 strobe idle");

    // R4 wide-mode bit only
    ireg_write(8'h4C, 8'h40);
    ireg_read(8'h4C, 8'hCA, "R4 mode bit set");
    ireg_write(8'h4C, 8'hFF);
    ireg_read(8'h4C, 8'hCA, "R4 other bits fixed");

    // R1 upper registers
    ireg_read(8'h59, 8'hA0, "R1 reg25");
    ireg_read(8'h5A, 8'hA0, "R1 reg26");
    ireg_read(8'h52, 8'h88, "R1 reg18");
    ireg_read(8'h53, 8'h88, "R1 reg19");

    // R5 ignored writes
    ireg_write(8'h56, 8'h55); ireg_read(8'h56, 8'h00, "R5 reg22");
    ireg_write(8'h5B, 8'h55); ireg_read(8'h5B, 8'h00, "R5 reg27");
    ireg_write(8'h5D, 8'h55); ireg_read(8'h5D, 8'h00, "R5 reg29");
    ireg_write(8'h4B, 8'h77); ireg_read(8'h4B, 8'h00, "R5 reg11");

    // R3 index width
    ireg_write(8'h54, 8'h3C);
    ireg_write(8'h44, 8'h11);
    ireg_read(8'h54, 8'h3C, "R3 wide reg20");
    ireg_write(8'h4C, 8'h00);
    ireg_read(8'h54, 8'h11, "R3 narrow alias to reg4");

    // R6 format gating
    ireg_write(8'h48, 8'hA5);
    check({7'b0, pb_upd}, 8'h01, "R10 strobe after full fmt write");
    check(pb_fmt, 8'hA5, "R6 full write");
    ireg_write(8'h08, 8'h3C);
    check({7'b0, pb_upd}, 8'h00, "R10 no strobe on discarded write");
    check(pb_fmt, 8'hA5, "R6 discarded write");
    ireg_write(8'h0C, 8'h40);
    ireg_write(8'h18, 8'h10);
    check(pb_alt, 8'h10, "R10 alt export");
    ireg_write(8'h08, 8'h3C);
    check({7'b0, pb_upd}, 8'h01, "R10 strobe after partial write");
    check(pb_fmt, 8'h35, "R6 partial write");

    // R7 reserved config bit
    ireg_write(8'h09, 8'hFF);
    check({7'b0, pb_upd}, 8'h01, "R10 strobe after cfg write");
    check(pb_cfg, 8'hDF, "R7 cfg export");
    ireg_read(8'h09, 8'hDF, "R7 cfg readback");

    // R10 other exports
    ireg_write(8'h0A, 8'h12);
    check({7'b0, pb_upd}, 8'h00, "R10 no strobe on pin write");
    check(pb_pin, 8'h12, "R10 pin export");
    ireg_write(8'h0E, 8'h34); check(pb_cnt_hi, 8'h34, "R10 count hi export");
    ireg_write(8'h0F, 8'h56); check(pb_cnt_lo, 8'h56, "R10 count lo export");

    // R8 calibration flag
    bus_write(2'd0, 8'h0B);
    bus_write(2'd0, 8'h4B);
    bus_read(2'd1, 8'h20, "R8 flag first read");
    bus_read(2'd1, 8'h00, "R8 flag expired");
    ireg_write(8'h49, 8'h00);
    bus_write(2'd0, 8'h0B);
    bus_write(2'd0, 8'h4B);
    bus_read(2'd1, 8'h00, "R8 no load when unarmed");

    // R9 status and PIO
    pb_irq = 1'b1;
    bus_read(2'd2, 8'h01, "R9 status irq set");
    pb_irq = 1'b0;
    bus_read(2'd2, 8'h00, "R9 status irq clear");
    bus_write(2'd3, 8'h55);
    bus_read(2'd3, 8'h00, "R9 pio port");

    // R2 pointer bit 7
    bus_write(2'd0, 8'hC5);
    bus_read(2'd0, 8'h45, "R2 pointer msb dropped");

    // R11 hold
    repeat (3) @(negedge clk);
    check(bus_rdata, 8'h45, "R11 rdata held");

    repeat (2) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL scoreboard: %0d reads pending, expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule